// File: doc/BRIEF.md
# Erase/Write Cycle Sequencer

This block runs the self-timed programming cycle of a small serial EEPROM once a write transaction has closed. A one-cycle start request carries four things: the target address, one or two data bytes with a byte-count flag, and a timing-mode flag that was captured earlier from the TEST pin. From that moment the block is busy. For each byte it runs an erase phase and then a write phase. A divider turns the timing clock into phase boundaries. At the end of every write phase the block sends a one-cycle write strobe with its address and data to the array.

The timing clock comes from one of two sources. It is either the free-running internal oscillator tick or the rising edges of the external TEST pin. The TEST pin is synchronised and edge-detected inside the block. The mode flag is latched when the request is accepted, so later changes on the flag input have no effect until the next cycle. The state machine has four states. ST_IDLE accepts a request and moves to ST_ERASE. ST_ERASE moves to ST_WRITE when the divider reaches its end. ST_WRITE moves back to ST_ERASE if a second byte is pending, and otherwise to ST_FINISH, in both cases when the divider reaches its end. ST_FINISH returns to ST_IDLE on the next timing tick.

Top module: `prog_cycle_seq`

## Requirements
- R1: After reset `busy`, `erasing`, `writing` and `wr_stb` are all 0.
- R2: A `start_req` sampled while idle makes `busy` and `erasing` read 1 from the next clock edge onward.
- R3: With `ext_timing`=0 at acceptance, the cycle ends after exactly 1+2·DIV·N internal `osc_tick` pulses, where N=1 when `two_bytes`=0 and N=2 when `two_bytes`=1. Rising edges on `test_pin` do not advance the cycle.
- R4: With `ext_timing`=1 at acceptance, the cycle ends after exactly 1+2·DIV·N rising edges on `test_pin`. `osc_tick` pulses do not advance the cycle.
- R5: Exactly N single-cycle `wr_stb` pulses occur per cycle. Strobe k (k=1..N) occurs after 2·DIV·k timing ticks, which is the end of that byte's write phase.
- R6: The first strobe carries `base_addr` and `wr_data0`. The second strobe carries `base_addr`+1 modulo 2^ADDR_W and `wr_data1`.
- R7: A `start_req` while `busy` is 1 is ignored. This includes a request in the same clock as the terminating tick. It changes neither the tick count, the strobe addresses or data, nor `busy` after the cycle ends.
- R8: `ext_timing` and `two_bytes` are used only at acceptance. Changing them mid-cycle does not alter the cycle.
- R9: `erasing` is 1 during the first DIV ticks of each byte, and `writing` is 1 during the next DIV ticks. The two are never 1 together, and neither is 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | One-cycle request to begin a programming cycle |
| two_bytes | input | 1 | 0: one byte, 1: two bytes |
| ext_timing | input | 1 | 1: time the cycle with TEST pulses, 0: internal oscillator |
| base_addr | input | ADDR_W | Address of the first byte |
| wr_data0 | input | DATA_W | First data byte |
| wr_data1 | input | DATA_W | Second data byte |
| osc_tick | input | 1 | Internal oscillator tick, one clock wide |
| test_pin | input | 1 | External TEST pin level |
| busy | output | 1 | Programming cycle in progress |
| erasing | output | 1 | Erase phase active |
| writing | output | 1 | Write phase active |
| wr_stb | output | 1 | One-cycle write strobe to the array |
| wr_addr | output | ADDR_W | Array address for the strobe |
| wr_data | output | DATA_W | Array data for the strobe |

## Verification
A new request and the terminating tick of the running cycle can arrive in the same clock. Then acceptance in ST_IDLE and the ST_FINISH-to-ST_IDLE transition compete. The bench provokes this in internal mode by raising `start_req` with a different address in the very cycle that carries the final oscillator tick. It then judges at the ports that `busy` falls and stays low and that no extra strobe appears. Stray pulses on the unselected timing source are injected throughout every run, and mid-cycle requests are issued, to show that the tick counts stay exact.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ERASE  = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } pcs_state_e;
endpackage

// File: rtl/pcs_tick_src.sv
module pcs_tick_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic osc_tick,
    input  logic test_pin,
    output logic tick
);
    // Synchroniser chain plus one history flop for edge detection.
    // TEST idles high, so the chain resets to 1.
    logic [SYNC_STAGES:0] sync_q;
    logic                 ext_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], test_pin};
    end

    assign ext_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign tick     = ext_sel ? ext_edge : osc_tick;

    // A detected rising edge lasts exactly one clock.
    AST_EXT_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_edge |=> !ext_edge); // R4
endmodule

// File: rtl/pcs_divider.sv
module pcs_divider #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic phase_end
);
    localparam int                CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (tick)       cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign phase_end = tick && (cnt == LAST);
endmodule

// File: rtl/pcs_fsm.sv
module pcs_fsm
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              two_bytes,
    input  logic              ext_timing,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] wr_data0,
    input  logic [DATA_W-1:0] wr_data1,
    input  logic              tick,
    input  logic              phase_end,
    output logic              mode_q,
    output logic              div_clear,
    output logic              busy,
    output logic              erasing,
    output logic              writing,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    pcs_state_e        state, state_nxt;
    logic              two_q;
    logic              byte_idx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] d0_q, d1_q;
    logic              accept;
    logic              more_bytes;

    assign accept     = (state == ST_IDLE) && start_req;
    assign more_bytes = two_q && !byte_idx;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start_req) state_nxt = ST_ERASE;
            ST_ERASE:  if (phase_end) state_nxt = ST_WRITE;
            ST_WRITE:  if (phase_end) state_nxt = more_bytes ? ST_ERASE : ST_FINISH;
            ST_FINISH: if (tick)      state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Registered outputs and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            two_q    <= 1'b0;
            byte_idx <= 1'b0;
            addr_q   <= '0;
            d0_q     <= '0;
            d1_q     <= '0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (accept) begin
                mode_q   <= ext_timing;
                two_q    <= two_bytes;
                byte_idx <= 1'b0;
                addr_q   <= base_addr;
                d0_q     <= wr_data0;
                d1_q     <= wr_data1;
            end
            if ((state == ST_WRITE) && phase_end) begin
                wr_stb  <= 1'b1;
                wr_addr <= addr_q + {{(ADDR_W-1){1'b0}}, byte_idx};
                wr_data <= byte_idx ? d1_q : d0_q;
                if (more_bytes) byte_idx <= 1'b1;
            end
        end
    end

    assign busy      = (state != ST_IDLE);
    assign erasing   = (state == ST_ERASE);
    assign writing   = (state == ST_WRITE);
    assign div_clear = (state == ST_IDLE);

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req) |=> (busy && erasing)); // R2
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R5
    AST_STB_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy); // R5
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q)); // R8
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erasing, writing}) && ((erasing || writing) -> busy)); // R9
endmodule

// File: rtl/prog_cycle_seq.sv
module prog_cycle_seq #(
    parameter int DIV         = 128,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              two_bytes,
    input  logic              ext_timing,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] wr_data0,
    input  logic [DATA_W-1:0] wr_data1,
    input  logic              osc_tick,
    input  logic              test_pin,
    output logic              busy,
    output logic              erasing,
    output logic              writing,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic mode_q;
    logic tick;
    logic phase_end;
    logic div_clear;

    pcs_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_sel  (mode_q),
        .osc_tick (osc_tick),
        .test_pin (test_pin),
        .tick     (tick)
    );

    pcs_divider #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (div_clear),
        .tick      (tick),
        .phase_end (phase_end)
    );

    pcs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .two_bytes  (two_bytes),
        .ext_timing (ext_timing),
        .base_addr  (base_addr),
        .wr_data0   (wr_data0),
        .wr_data1   (wr_data1),
        .tick       (tick),
        .phase_end  (phase_end),
        .mode_q     (mode_q),
        .div_clear  (div_clear),
        .busy       (busy),
        .erasing    (erasing),
        .writing    (writing),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );
endmodule

// File: tb/prog_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module prog_cycle_seq_tb_top;
    localparam int DIV = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic       two_bytes = 1'b0;
    logic       ext_timing = 1'b0;
    logic [7:0] base_addr = '0;
    logic [7:0] wr_data0 = '0;
    logic [7:0] wr_data1 = '0;
    logic       osc_tick = 1'b0;
    logic       test_pin = 1'b1;
    logic       busy, erasing, writing, wr_stb;
    logic [7:0] wr_addr, wr_data;

    int checks = 0;
    int fails  = 0;
    int ticks_done = 0;
    int stb_n = 0;
    int stb_tick [2];
    logic [7:0] stb_addr [2];
    logic [7:0] stb_dat  [2];

    always #5 clk = ~clk;

    prog_cycle_seq #(.DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .two_bytes(two_bytes),
        .ext_timing(ext_timing), .base_addr(base_addr), .wr_data0(wr_data0),
        .wr_data1(wr_data1), .osc_tick(osc_tick), .test_pin(test_pin),
        .busy(busy), .erasing(erasing), .writing(writing), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (stb_n < 2) begin
                stb_tick[stb_n] = ticks_done;
                stb_addr[stb_n] = wr_addr;
                stb_dat[stb_n]  = wr_data;
            end
            stb_n = stb_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One timing tick on the selected source, with a stray pulse on the other.
    task automatic give_tick(input bit ext, input bit late_req);
        ticks_done++;
        @(negedge clk);
        if (ext) begin
            test_pin = 1'b1;
            osc_tick = 1'b1;
            @(negedge clk);
            osc_tick = 1'b0;
            repeat (2) @(negedge clk);
            test_pin = 1'b0;
            repeat (3) @(negedge clk);
        end else begin
            osc_tick = 1'b1;
            test_pin = 1'b0;
            if (late_req) begin
                start_req = 1'b1;
                base_addr = 8'hA5;
            end
            @(negedge clk);
            osc_tick  = 1'b0;
            start_req = 1'b0;
            repeat (2) @(negedge clk);
            test_pin = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic run(input bit ext, input bit two, input logic [7:0] base,
                       input logic [7:0] d0, input logic [7:0] d1);
        int n;
        int total;
        n = two ? 2 : 1;
        total = 1 + 2 * DIV * n;
        @(negedge clk);
        test_pin = ext ? 1'b0 : 1'b1;
        repeat (5) @(negedge clk);
        stb_n = 0;
        ticks_done = 0;
        two_bytes = two; ext_timing = ext; base_addr = base;
        wr_data0 = d0; wr_data1 = d1; start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        ext_timing = ~ext;
        two_bytes = ~two;
        chk(busy === 1'b1, "R2 busy after start", busy, 1);
        chk(erasing === 1'b1 && writing === 1'b0, "R9 erase first", erasing, 1);
        for (int i = 1; i <= total; i++) begin
            if (i == DIV / 2) begin
                @(negedge clk);
                start_req = 1'b1; base_addr = ~base;
                @(negedge clk);
                start_req = 1'b0;
            end
            give_tick(ext, (i == total) && !ext);
            if (i == DIV - 1)
                chk(erasing === 1'b1, "R9 still erasing", erasing, 1);
            if (i == DIV)
                chk(writing === 1'b1 && erasing === 1'b0, "R9 writing phase", writing, 1);
            if (i == total - 1)
                chk(busy === 1'b1, ext ? "R4 busy before last" : "R3 busy before last", busy, 1);
            if (i == total)
                chk(busy === 1'b0, ext ? "R4 done on last pulse" : "R3 done on last tick", busy, 0);
        end
        repeat (6) @(negedge clk);
        chk(busy === 1'b0, "R7 late request ignored", busy, 0);
        chk(stb_n == n, "R5 strobe count (R8 two_bytes latched)", stb_n, n);
        chk(stb_tick[0] == 2 * DIV, "R5 first strobe tick", stb_tick[0], 2 * DIV);
        chk(stb_addr[0] == base && stb_dat[0] == d0, "R6 first addr/data (R7)",
            {stb_addr[0], stb_dat[0]}, {base, d0});
        if (two) begin
            chk(stb_tick[1] == 4 * DIV, "R5 second strobe tick", stb_tick[1], 4 * DIV);
            chk(stb_addr[1] == 8'(base + 8'd1) && stb_dat[1] == d1, "R6 second addr/data",
                {stb_addr[1], stb_dat[1]}, {8'(base + 8'd1), d1});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && erasing === 1'b0 && writing === 1'b0, "R1 idle after reset", busy, 0);
        chk(wr_stb === 1'b0, "R1 no strobe after reset", wr_stb, 0);
        run(1'b0, 1'b0, 8'h10, 8'h5A, 8'hC3);
        run(1'b0, 1'b1, 8'hFF, 8'h01, 8'h80);
        run(1'b1, 1'b0, 8'h00, 8'hFF, 8'h00);
        run(1'b1, 1'b1, 8'h7F, 8'h33, 8'hCC);
        run(1'b1, 1'b1, 8'hFF, 8'h96, 8'h69);
        run(1'b0, 1'b1, 8'h3C, 8'h00, 8'hFF);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule